// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Read Master

This block runs read cycles on an external bus where address and data share one set of lines. It works from a clock that runs at eight times the instruction-cycle rate. Each bus cycle therefore takes exactly eight clocks, and every edge of the address latch strobe, the read strobe and the bus turnaround sits on a fixed phase of that grid. The address is driven while the latch strobe is high. The shared lines are then released, and the read strobe goes low for half the cycle. The data is captured on the clock edge at which the read strobe goes high again.

A host places an address on `req_addr` and raises `req`. The request is taken on any clock edge where `rdy` is high. `busy` then stays high for the eight clocks of that bus cycle. One clock after the data is captured, `done` pulses for one clock with the data on `rdata`. A request taken in the last phase of a cycle starts the next bus cycle straight away, with no idle clock between the two. While reset is asserted, and while the bus is idle, the control lines are driven to their idle levels and the shared lines are driven by the master, so the external memory never sees floating strobes.

Top module: `mux_bus_reader`

## Requirements
- R1: A bus cycle lasts exactly 8 clocks, called phases 0 to 7. Phase 0 is the first clock after the edge that accepts the request. Consecutive latch-strobe rising edges are 8 clocks apart when requests follow each other.
- R2: `addr_latch` is high in phases 0 and 1 only. During those phases `ad_oe` is 1 and `ad_o` carries the accepted address.
- R3: `ad_oe` is 0 in phases 2 to 7. `rd_strobe_n` is 0 in phases 3 to 6 only. `ad_oe` and a low `rd_strobe_n` are never active together.
- R4: `ad_i` is captured at the clock edge that ends phase 6. `done` is 1 for exactly the one clock of phase 7, and `rdata` then holds the captured value.
- R5: `sel_n` is 0 through all eight phases of every bus cycle and 1 whenever no cycle is running.
- R6: `rdy` is 1 when the bus is idle or in phase 7, and 0 otherwise. A request is accepted on a rising clock edge where both `req` and `rdy` are 1. `busy` is 1 for exactly the 8 phases of each accepted request.
- R7: A request accepted in phase 7 begins phase 0 of the next cycle on the following clock. `sel_n` stays 0 across the boundary between the two cycles.
- R8: While `rst` is 1, the outputs are forced to their idle levels in the same clock, before any clock edge: `addr_latch` 0, `rd_strobe_n` 1, `sel_n` 1, `ad_oe` 1, `ad_o` 0. A request held during reset is ignored. After reset, `busy` and `done` are 0.
- R9: While idle, `ad_oe` is 1 and `ad_o` holds the last accepted address, or 0 if no address has been accepted since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, eight per instruction cycle |
| rst | input | 1 | Synchronous active-high reset; also forces idle levels at once |
| req | input | 1 | Host read request |
| req_addr | input | AD_W | Address of the requested read |
| rdy | output | 1 | A request is taken at the next edge if `req` is high |
| busy | output | 1 | A bus cycle is running |
| done | output | 1 | One-clock pulse: `rdata` is valid |
| rdata | output | AD_W | Captured read data |
| addr_latch | output | 1 | Address latch strobe, active high, idles low |
| rd_strobe_n | output | 1 | Read strobe, active low, idles high |
| sel_n | output | 1 | Chip select, active low, idles high |
| ad_o | output | AD_W | Value driven onto the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_i | input | AD_W | Value sampled from the shared lines |

## Verification
Two things can happen in the same clock. Phase 7 of one cycle carries the `done` strobe and its data, and that same clock is also where the next request is accepted. The bench provokes this with table entries that have no gap, so `req` is held high with a new address while the previous cycle finishes. For each such pair it checks that `rdata` matches the memory value of the earlier address. It also checks that the next clock shows the later address under a rising latch strobe, with `sel_n` held low throughout. A reset asserted while the read strobe is low checks the other collision: the strobes must return to their idle levels within the same clock, not at the next edge.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
  localparam int PH_N = 8;
  localparam int PH_W = $clog2(PH_N);
  typedef logic [PH_W-1:0] phase_t;

  // phase grid in eighths of an instruction cycle
  localparam phase_t PH_LATCH_LAST = phase_t'(1);
  localparam phase_t PH_RD_FIRST   = phase_t'(3);
  localparam phase_t PH_RD_LAST    = phase_t'(6);
  localparam phase_t PH_END        = phase_t'(PH_N - 1);

  function automatic logic latch_on(input logic act, input phase_t ph);
    return act && (ph <= PH_LATCH_LAST);
  endfunction

  function automatic logic read_on(input logic act, input phase_t ph);
    return act && (ph >= PH_RD_FIRST) && (ph <= PH_RD_LAST);
  endfunction

  function automatic logic drive_on(input logic act, input phase_t ph);
    return !act || (ph <= PH_LATCH_LAST);
  endfunction
endpackage

// File: rtl/mux_bus_timebase.sv
module mux_bus_timebase
  import mux_bus_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output logic   act,
  output phase_t ph,
  output logic   nxt_act,
  output phase_t nxt_ph,
  output logic   rdy
);
  always_comb begin
    nxt_act = act;
    nxt_ph  = ph;
    if (start) begin
      nxt_act = 1'b1;
      nxt_ph  = '0;
    end else if (act) begin
      if (ph == PH_END) begin
        nxt_act = 1'b0;
        nxt_ph  = '0;
      end else begin
        nxt_ph = ph + phase_t'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0;
      ph  <= '0;
    end else begin
      act <= nxt_act;
      ph  <= nxt_ph;
    end
  end

  assign rdy = !act || (ph == PH_END);
endmodule

// File: rtl/mux_bus_pins.sv
module mux_bus_pins
  import mux_bus_pkg::*;
#(
  parameter int AD_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AD_W-1:0] req_addr,
  input  logic            nxt_act,
  input  phase_t          nxt_ph,
  output logic            addr_latch,
  output logic            rd_strobe_n,
  output logic            sel_n,
  output logic [AD_W-1:0] ad_o,
  output logic            ad_oe
);
  logic            latch_q, rd_n_q, sel_n_q, oe_q;
  logic [AD_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= 1'b0;
      rd_n_q  <= 1'b1;
      sel_n_q <= 1'b1;
      oe_q    <= 1'b1;
      addr_q  <= '0;
    end else begin
      latch_q <= latch_on(nxt_act, nxt_ph);
      rd_n_q  <= !read_on(nxt_act, nxt_ph);
      sel_n_q <= !nxt_act;
      oe_q    <= drive_on(nxt_act, nxt_ph);
      if (start) addr_q <= req_addr;
    end
  end

  // reset overrides the registers at once so no strobe floats or glitches
  assign addr_latch  = latch_q & ~rst;
  assign rd_strobe_n = rd_n_q | rst;
  assign sel_n       = sel_n_q | rst;
  assign ad_oe       = oe_q | rst;
  assign ad_o        = rst ? '0 : addr_q;
endmodule

// File: rtl/mux_bus_capture.sv
module mux_bus_capture
  import mux_bus_pkg::*;
#(
  parameter int AD_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            act,
  input  phase_t          ph,
  input  logic [AD_W-1:0] ad_i,
  output logic            done,
  output logic [AD_W-1:0] rdata
);
  logic take;
  assign take = act && (ph == PH_RD_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= take;
      if (take) rdata <= ad_i;
    end
  end
endmodule

// File: rtl/mux_bus_reader.sv
module mux_bus_reader
  import mux_bus_pkg::*;
#(
  parameter int AD_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic [AD_W-1:0] req_addr,
  output logic            rdy,
  output logic            busy,
  output logic            done,
  output logic [AD_W-1:0] rdata,
  output logic            addr_latch,
  output logic            rd_strobe_n,
  output logic            sel_n,
  output logic [AD_W-1:0] ad_o,
  output logic            ad_oe,
  input  logic [AD_W-1:0] ad_i
);
  logic   act, nxt_act, start;
  phase_t ph, nxt_ph;

  assign start = req && rdy;
  assign busy  = act;

  mux_bus_timebase u_tb (
    .clk(clk), .rst(rst), .start(start), .act(act), .ph(ph),
    .nxt_act(nxt_act), .nxt_ph(nxt_ph), .rdy(rdy)
  );

  mux_bus_pins #(.AD_W(AD_W)) u_pins (
    .clk(clk), .rst(rst), .start(start), .req_addr(req_addr),
    .nxt_act(nxt_act), .nxt_ph(nxt_ph), .addr_latch(addr_latch),
    .rd_strobe_n(rd_strobe_n), .sel_n(sel_n), .ad_o(ad_o), .ad_oe(ad_oe)
  );

  mux_bus_capture #(.AD_W(AD_W)) u_cap (
    .clk(clk), .rst(rst), .act(act), .ph(ph), .ad_i(ad_i),
    .done(done), .rdata(rdata)
  );
endmodule

// File: rtl/mux_bus_reader_chk.sv
module mux_bus_reader_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic addr_latch,
  input logic rd_strobe_n,
  input logic sel_n,
  input logic ad_oe
);
  // R8
  always @(posedge clk) begin
    if (rst) begin
      reset_idle_chk: assert (!addr_latch && rd_strobe_n && sel_n && ad_oe)
        else $error("control lines not idle during reset");
    end
  end

  // R3
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe_n |-> !ad_oe);

  // R2
  latch_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_latch) |=> addr_latch ##1 !addr_latch);

  // R4
  done_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (rd_strobe_n && $past(!rd_strobe_n)));

  // R5
  select_covers_read_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe_n |-> !sel_n);

  // R6
  done_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
endmodule

bind mux_bus_reader mux_bus_reader_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .addr_latch(addr_latch),
  .rd_strobe_n(rd_strobe_n), .sel_n(sel_n), .ad_oe(ad_oe)
);

// File: tb/tb_mux_bus_reader.sv
module tb_mux_bus_reader;
  localparam int AD_W = 16;
  localparam int NV = 8;
  localparam logic [AD_W-1:0] V_ADDR [NV] = '{16'h1234, 16'h0000, 16'hFFFF,
    16'hA5A5, 16'h5A5A, 16'h00FF, 16'hFF00, 16'h8001};
  localparam int V_GAP [NV] = '{2, 0, 0, 3, 0, 1, 0, 0};

  logic clk = 0, rst = 1, req = 0;
  logic [AD_W-1:0] req_addr = '0;
  logic rdy, busy, done, addr_latch, rd_strobe_n, sel_n, ad_oe;
  logic [AD_W-1:0] rdata, ad_o, ad_i, lat = '0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mux_bus_reader #(.AD_W(AD_W)) dut (.*);

  function automatic logic [AD_W-1:0] mem(input logic [AD_W-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C96;
  endfunction

  // external memory model: latches the address on the falling latch strobe
  always @(negedge addr_latch) lat <= ad_o;
  assign ad_i = !rd_strobe_n ? mem(lat) : 16'hDEAD;

  // reference model built from the requirements
  logic mact = 0, mdone = 0;
  int mph = 0;
  logic [AD_W-1:0] madr = '0, mcap = '0;
  always @(posedge clk) begin
    if (rst) begin
      mact <= 0; mph <= 0; mdone <= 0; madr <= '0;
    end else begin
      mdone <= mact && mph == 6;
      if (mact && mph == 6) mcap <= madr;
      if (req && (!mact || mph == 7)) begin
        mact <= 1; mph <= 0; madr <= req_addr;
      end else if (mact && mph == 7) begin
        mact <= 0; mph <= 0;
      end else if (mact) mph <= mph + 1;
    end
  end

  task automatic chk(input logic [AD_W-1:0] act_v, input logic [AD_W-1:0] exp_v,
                     input string tag);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act_v, exp_v);
    end
  endtask

  // cycle-by-cycle monitor, sampled 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    if (rst) begin
      chk(addr_latch, 0, "R8 latch idle in reset");
      chk(rd_strobe_n, 1, "R8 read strobe idle in reset");
      chk(sel_n, 1, "R8 select idle in reset");
      chk(ad_oe, 1, "R8 bus driven in reset");
      chk(ad_o, '0, "R8 bus value in reset");
    end else begin
      chk(addr_latch, mact && mph < 2, "R2 latch strobe phase");
      chk(rd_strobe_n, !(mact && mph >= 3 && mph <= 6), "R3 read strobe phase");
      chk(ad_oe, !mact || mph < 2, "R3 bus release phase");
      chk(sel_n, !mact, "R5 select level");
      chk(busy, mact, "R6 busy level");
      chk(rdy, !mact || mph == 7, "R6 ready level");
      chk(done, mdone, "R4 done pulse");
      if (mdone) chk(rdata, mem(mcap), "R4 captured data");
      chk(ad_o, madr, "R9 address on bus");
    end
  end

  task automatic issue(input logic [AD_W-1:0] a);
    req = 1; req_addr = a;
    forever begin
      if (rdy) begin
        @(posedge clk); @(negedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  int rise_t [$];
  always @(posedge addr_latch) rise_t.push_back(int'($time));

  initial begin
    #1;
    chk(addr_latch, 0, "R8 latch idle at time zero");
    chk(sel_n, 1, "R8 select idle at time zero");
    req = 1; req_addr = 16'h7777;  // R8: request ignored while in reset
    repeat (3) @(negedge clk);
    chk(busy, 0, "R8 busy low in reset with req held");
    req = 0; rst = 0;
    @(negedge clk); @(negedge clk);
    chk(done, 0, "R8 done low after reset");
    chk(ad_o, '0, "R9 bus zero after reset");

    // table walk: gap 0 entries run back-to-back (R7)
    for (int i = 0; i < NV; i++) begin
      if (V_GAP[i] > 0) begin
        req = 0;
        while (busy) @(negedge clk);
        repeat (V_GAP[i]) @(negedge clk);
      end
      issue(V_ADDR[i]);
    end
    req = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);

    // R1 / R7: latch strobe period in the back-to-back run (entries 0..2)
    if (rise_t.size() >= 3) begin
      chk(16'(rise_t[1] - rise_t[0]), 16'd160, "R1 R7 back-to-back latch period");
      chk(16'(rise_t[2] - rise_t[1]), 16'd160, "R1 R7 back-to-back latch period 2");
    end else chk(16'(rise_t.size()), 16'd3, "R1 latch rises seen");

    // R8: reset during read strobe low forces idle in the same clock
    issue(16'hBEEF);
    req = 0;
    repeat (3) @(negedge clk);
    rst = 1;
    #2;
    chk(rd_strobe_n, 1, "R8 read strobe forced high mid-cycle");
    chk(sel_n, 1, "R8 select forced high mid-cycle");
    chk(ad_oe, 1, "R8 bus driven mid-cycle");
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy, 0, "R8 idle after mid-cycle reset");
    issue(16'h4242);
    req = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule